// File: doc/BRIEF.md
# Exception Vector Entry Sequencer

This block performs exception and interrupt entry for a small 32-bit processor core. Each cycle it looks at three kinds of request: a software break that carries a trap number, an address-translation miss, and a 32-bit mask of pending hardware interrupts. It selects one cause and derives a vector index from it. It then fetches the handler address from a table in memory and returns a set of register write-back strobes. Those strobes load the program counter with the handler address, save a return address that depends on the cause, and update the status word so that the previous flag state moves up into a stacked field.

The vector fetch leaves the block as a one-word read on a valid/ready request channel. The response comes back on a valid-only channel. Once it has accepted a request, the block keeps the read request valid, with a stable address, until the memory side raises ready. The block then waits for one response beat. It has no back-pressure on the response side, and any response beat that arrives while no read is outstanding is dropped. `busy` is high from acceptance through the write-back cycle. While it is high the request inputs are not sampled.

Top module: `exc_entry_seq`

## Requirements
- R1: The read request address is `vbase_in + 4*index`. While `mem_req_valid` is high and `mem_req_ready` is low, `mem_req_valid` stays high and `mem_req_addr` does not change the next cycle.
- R2: For a break, the index equals `brk_trapno` zero-extended, and the saved return address is `pc_in + 2`.
- R3: For a translation miss, the index is 4 and the saved return address is `pc_in`.
- R4: For a hardware interrupt, the index is 0x30 plus the position of the highest set bit of `irq_pend`, and the saved return address is `pc_in`.
- R5: A hardware interrupt alone is not taken when `irq_pend` is zero or when the enable flag `stat_in[2]` is 0. In that case `busy`, `mem_req_valid` and every write strobe stay low.
- R6: The written status word is `{old[31:30], old[19:0], 10'b0}`, where `old` is `stat_in` as sampled at acceptance.
- R7: In the cycle after the response beat is taken, `done`, `pc_we`, `ret_we` and `stat_we` are all high for exactly one cycle. In that cycle `pc_wdata` equals the fetched word and `ret_wdata` and `stat_wdata` carry the values from R2 to R6. `busy` stays high from the cycle after acceptance through that cycle.
- R8: When several requests are present together, a break wins over a miss, and a miss wins over an interrupt.
- R9: While `busy` is high, new requests are ignored. A response beat that arrives before the read request has been accepted is also ignored.
- R10: A synchronous active-high `rst` returns the block to idle with `busy`, `done` and `mem_req_valid` low, and it abandons any outstanding read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| brk_req | input | 1 | Software break request |
| brk_trapno | input | 8 | Trap number carried by the break |
| miss_req | input | 1 | Translation miss request |
| irq_pend | input | 32 | Pending hardware interrupt mask |
| pc_in | input | 32 | Current program counter |
| vbase_in | input | 32 | Vector table base register |
| stat_in | input | 32 | Current status word; bit 2 enables interrupts |
| mem_req_valid | output | 1 | Vector read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Vector read address |
| mem_rsp_valid | input | 1 | Read response beat valid |
| mem_rsp_data | input | 32 | Fetched handler address |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | One-cycle commit pulse |
| pc_we | output | 1 | Program counter write strobe |
| pc_wdata | output | 32 | New program counter |
| ret_we | output | 1 | Return address register write strobe |
| ret_wdata | output | 32 | Saved return address |
| stat_we | output | 1 | Status word write strobe |
| stat_wdata | output | 32 | Shifted status word |

## Verification
Several properties are checked every clock. The read request must stay valid with a stable address under back-pressure. The commit pulse must last one cycle and must follow a response beat. The written status must have its low field cleared. A lone interrupt that is masked or empty must never raise `busy`, the saved values must not move while the sequence runs, and an interrupt index must point at the highest set pending bit. The bench scenarios show the rest. They cover the exact vector addresses and return addresses for each cause, the priority when requests coincide, the fetched word arriving in `pc_wdata`, responses dropped before the request handshake completes, requests made while busy that have no effect, and a reset in the middle of a fetch.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE,
    CAUSE_BRK,
    CAUSE_MISS,
    CAUSE_IRQ
  } cause_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_COMMIT
  } seq_state_e;
endpackage

// File: rtl/exc_vec_sel.sv
module exc_vec_sel
  import exc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int PEND_W   = 32,
  parameter int TRAP_W   = 8,
  parameter int MISS_VEC = 4,
  parameter int IRQ_BASE = 48,
  localparam int POS_W   = $clog2(PEND_W)
) (
  input  logic              brk_req,
  input  logic [TRAP_W-1:0] brk_trapno,
  input  logic              miss_req,
  input  logic [PEND_W-1:0] irq_pend,
  input  logic              irq_enable,
  input  logic [XLEN-1:0]   pc_in,
  output cause_e            cause,
  output logic [XLEN-1:0]   vec_idx,
  output logic [XLEN-1:0]   ret_addr,
  output logic [POS_W-1:0]  irq_pos
);
  logic irq_ok;

  // highest set bit: later (higher) indices overwrite earlier ones
  always_comb begin
    irq_pos = '0;
    for (int i = 0; i < PEND_W; i++) begin
      if (irq_pend[i]) irq_pos = POS_W'(i);
    end
  end

  assign irq_ok = (|irq_pend) && irq_enable;

  always_comb begin
    cause    = CAUSE_NONE;
    vec_idx  = '0;
    ret_addr = pc_in;
    if (brk_req) begin
      cause    = CAUSE_BRK;
      vec_idx  = XLEN'(brk_trapno);
      ret_addr = pc_in + XLEN'(2);
    end else if (miss_req) begin
      cause    = CAUSE_MISS;
      vec_idx  = XLEN'(MISS_VEC);
    end else if (irq_ok) begin
      cause    = CAUSE_IRQ;
      vec_idx  = XLEN'(IRQ_BASE) + XLEN'(irq_pos);
    end
  end
endmodule

// File: rtl/exc_stat_shift.sv
module exc_stat_shift #(
  parameter int XLEN       = 32,
  parameter int STAT_KEEP  = 2,
  parameter int STAT_SHIFT = 10,
  localparam int LOW_W     = XLEN - STAT_KEEP - STAT_SHIFT
) (
  input  logic [STAT_KEEP-1:0] keep_bits,
  input  logic [LOW_W-1:0]     low_bits,
  output logic [XLEN-1:0]      stat_new
);
  assign stat_new = {keep_bits, low_bits, {STAT_SHIFT{1'b0}}};
endmodule

// File: rtl/exc_fetch_ctl.sv
module exc_fetch_ctl
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [XLEN-1:0] start_addr,
  output logic            idle,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [XLEN-1:0] req_addr,
  input  logic            rsp_valid,
  input  logic [XLEN-1:0] rsp_data,
  output logic            commit,
  output logic [XLEN-1:0] handler
);
  seq_state_e state_q, state_d;
  logic [XLEN-1:0] addr_q;
  logic [XLEN-1:0] handler_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start) state_d = ST_REQ;
      ST_REQ:    if (req_ready) state_d = ST_WAIT;
      ST_WAIT:   if (rsp_valid) state_d = ST_COMMIT;
      ST_COMMIT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      handler_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start) addr_q <= start_addr;
      if (state_q == ST_WAIT && rsp_valid) handler_q <= rsp_data;
    end
  end

  assign idle      = (state_q == ST_IDLE);
  assign req_valid = (state_q == ST_REQ);
  assign req_addr  = addr_q;
  assign commit    = (state_q == ST_COMMIT);
  assign handler   = handler_q;

  // R1: request held with stable address under back-pressure
  a_r1_req_hold: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  // R7: commit lasts exactly one cycle
  a_r7_commit_pulse: assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit);

  // R7: commit only follows a response beat
  a_r7_commit_after_rsp: assert property (@(posedge clk) disable iff (rst)
    commit |-> $past(rsp_valid));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int PEND_W     = 32,
  parameter int TRAP_W     = 8,
  parameter int IE_BIT     = 2,
  parameter int MISS_VEC   = 4,
  parameter int IRQ_BASE   = 48,
  parameter int STAT_KEEP  = 2,
  parameter int STAT_SHIFT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              brk_req,
  input  logic [TRAP_W-1:0] brk_trapno,
  input  logic              miss_req,
  input  logic [PEND_W-1:0] irq_pend,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   vbase_in,
  input  logic [XLEN-1:0]   stat_in,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [XLEN-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [XLEN-1:0]   mem_rsp_data,
  output logic              busy,
  output logic              done,
  output logic              pc_we,
  output logic [XLEN-1:0]   pc_wdata,
  output logic              ret_we,
  output logic [XLEN-1:0]   ret_wdata,
  output logic              stat_we,
  output logic [XLEN-1:0]   stat_wdata
);
  localparam int POS_W = $clog2(PEND_W);
  localparam int LOW_W = XLEN - STAT_KEEP - STAT_SHIFT;

  cause_e            sel_cause;
  logic [XLEN-1:0]   sel_idx;
  logic [XLEN-1:0]   sel_ret;
  logic [POS_W-1:0]  sel_pos;
  logic [XLEN-1:0]   stat_shifted;
  logic [XLEN-1:0]   vec_addr;
  logic              ctl_idle;
  logic              start;
  logic              commit;
  logic [XLEN-1:0]   handler;
  logic [XLEN-1:0]   ret_q;
  logic [XLEN-1:0]   stat_q;

  exc_vec_sel #(
    .XLEN(XLEN), .PEND_W(PEND_W), .TRAP_W(TRAP_W),
    .MISS_VEC(MISS_VEC), .IRQ_BASE(IRQ_BASE)
  ) u_sel (
    .brk_req    (brk_req),
    .brk_trapno (brk_trapno),
    .miss_req   (miss_req),
    .irq_pend   (irq_pend),
    .irq_enable (stat_in[IE_BIT]),
    .pc_in      (pc_in),
    .cause      (sel_cause),
    .vec_idx    (sel_idx),
    .ret_addr   (sel_ret),
    .irq_pos    (sel_pos)
  );

  exc_stat_shift #(
    .XLEN(XLEN), .STAT_KEEP(STAT_KEEP), .STAT_SHIFT(STAT_SHIFT)
  ) u_shift (
    .keep_bits (stat_in[XLEN-1 -: STAT_KEEP]),
    .low_bits  (stat_in[LOW_W-1:0]),
    .stat_new  (stat_shifted)
  );

  assign vec_addr = vbase_in + (sel_idx << 2);
  assign start    = ctl_idle && (sel_cause != CAUSE_NONE);

  exc_fetch_ctl #(.XLEN(XLEN)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_addr (vec_addr),
    .idle       (ctl_idle),
    .req_valid  (mem_req_valid),
    .req_ready  (mem_req_ready),
    .req_addr   (mem_req_addr),
    .rsp_valid  (mem_rsp_valid),
    .rsp_data   (mem_rsp_data),
    .commit     (commit),
    .handler    (handler)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_q  <= '0;
      stat_q <= '0;
    end else if (start) begin
      ret_q  <= sel_ret;
      stat_q <= stat_shifted;
    end
  end

  assign busy       = !ctl_idle;
  assign done       = commit;
  assign pc_we      = commit;
  assign ret_we     = commit;
  assign stat_we    = commit;
  assign pc_wdata   = handler;
  assign ret_wdata  = ret_q;
  assign stat_wdata = stat_q;

  // R5: a lone masked or empty interrupt never starts a sequence
  a_r5_irq_ignored: assert property (@(posedge clk) disable iff (rst)
    (!busy && !brk_req && !miss_req && ((irq_pend == '0) || !stat_in[IE_BIT]))
      |=> !busy);

  // R6: low status field is cleared on write
  a_r6_low_clear: assert property (@(posedge clk) disable iff (rst)
    stat_we |-> (stat_wdata[STAT_SHIFT-1:0] == '0));

  // R9: saved values do not move while a sequence runs
  a_r9_hold_saved: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> ($stable(ret_wdata) && $stable(stat_wdata)));

  // R4: interrupt index points at the highest pending bit
  a_r4_top_bit: assert property (@(posedge clk) disable iff (rst)
    (start && sel_cause == CAUSE_IRQ) |-> ((irq_pend >> sel_pos) == PEND_W'(1)));
endmodule

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        brk_req = 1'b0;
  logic [7:0]  brk_trapno = '0;
  logic        miss_req = 1'b0;
  logic [31:0] irq_pend = '0;
  logic [31:0] pc_in = '0;
  logic [31:0] vbase_in = '0;
  logic [31:0] stat_in = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        busy, done, pc_we, ret_we, stat_we;
  logic [31:0] pc_wdata, ret_wdata, stat_wdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_seq i_exc_entry_seq (
    .clk(clk), .rst(rst), .brk_req(brk_req), .brk_trapno(brk_trapno),
    .miss_req(miss_req), .irq_pend(irq_pend), .pc_in(pc_in),
    .vbase_in(vbase_in), .stat_in(stat_in),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .busy(busy), .done(done),
    .pc_we(pc_we), .pc_wdata(pc_wdata), .ret_we(ret_we),
    .ret_wdata(ret_wdata), .stat_we(stat_we), .stat_wdata(stat_wdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] shifted(input logic [31:0] s);
    return {s[31:30], s[19:0], 10'b0};
  endfunction

  task automatic clear_reqs();
    brk_req = 1'b0; miss_req = 1'b0; irq_pend = '0;
  endtask

  // one full entry; idx and ret are the expected vector index and return address
  task automatic run_entry(input string req, input logic b, input logic [7:0] t,
                           input logic m, input logic [31:0] p, input logic [31:0] pc,
                           input logic [31:0] base, input logic [31:0] st,
                           input int delay, input logic [31:0] idx,
                           input logic [31:0] ret, input logic [31:0] data);
    logic [31:0] exp_addr;
    exp_addr = base + idx * 4;
    @(negedge clk);
    brk_req = b; brk_trapno = t; miss_req = m; irq_pend = p;
    pc_in = pc; vbase_in = base; stat_in = st;
    mem_req_ready = 1'b0;
    @(negedge clk);
    chk({req, " busy after accept (R7)"}, 32'(busy), 1);
    chk({req, " req valid (R1)"}, 32'(mem_req_valid), 1);
    chk({req, " vector address (R1)"}, mem_req_addr, exp_addr);
    // R9: fresh requests and altered inputs while busy must not matter
    brk_req = 1'b1; brk_trapno = 8'h77; miss_req = 1'b1; irq_pend = 32'hFFFF_FFFF;
    pc_in = 32'hDEAD_0000; stat_in = 32'h0000_0000;
    for (int k = 0; k < delay; k++) begin
      mem_rsp_valid = 1'b1; mem_rsp_data = 32'hBAD0_BAD0;
      @(negedge clk);
      chk({req, " req held under back-pressure (R1)"}, 32'(mem_req_valid), 1);
      chk({req, " address stable (R1)"}, mem_req_addr, exp_addr);
      chk({req, " early response ignored (R9)"}, 32'(done), 0);
    end
    mem_rsp_valid = 1'b0;
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk({req, " req dropped after handshake (R1)"}, 32'(mem_req_valid), 0);
    chk({req, " no done while waiting (R7)"}, 32'(done), 0);
    mem_rsp_valid = 1'b1; mem_rsp_data = data;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    clear_reqs();
    chk({req, " done pulse (R7)"}, 32'(done), 1);
    chk({req, " write strobes (R7)"}, {29'b0, pc_we, ret_we, stat_we}, 32'h7);
    chk({req, " busy in commit (R7)"}, 32'(busy), 1);
    chk({req, " new pc (R7)"}, pc_wdata, data);
    chk({req, " return address"}, ret_wdata, ret);
    chk({req, " status shift (R6)"}, stat_wdata, shifted(st));
    @(negedge clk);
    chk({req, " done one cycle (R7)"}, 32'(done), 0);
    chk({req, " idle after commit (R7)"}, 32'(busy), 0);
  endtask

  task automatic expect_ignored(input string req, input logic [31:0] p, input logic [31:0] st);
    @(negedge clk);
    brk_req = 1'b0; miss_req = 1'b0; irq_pend = p; stat_in = st;
    @(negedge clk);
    chk({req, " not busy (R5)"}, 32'(busy), 0);
    chk({req, " no read (R5)"}, 32'(mem_req_valid), 0);
    @(negedge clk);
    chk({req, " no writes (R5)"}, {29'b0, pc_we, ret_we, stat_we}, 0);
    clear_reqs();
  endtask

  task automatic test_reset_midway();
    @(negedge clk);
    miss_req = 1'b1; vbase_in = 32'h100; pc_in = 32'h50; stat_in = 32'h4;
    @(negedge clk);
    clear_reqs();
    chk("R10 busy before reset", 32'(busy), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 busy cleared", 32'(busy), 0);
    chk("R10 read abandoned", 32'(mem_req_valid), 0);
    mem_rsp_valid = 1'b1; mem_rsp_data = 32'h1234;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk("R10 stray response no done", 32'(done), 0);
    chk("R9 stray response no busy", 32'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset busy", 32'(busy), 0);
    chk("R10 reset done", 32'(done), 0);
    chk("R10 reset req", 32'(mem_req_valid), 0);
    rst = 1'b0;
    // R2 break
    run_entry("R2 break", 1, 8'h11, 0, 0, 32'h1000, 32'h8000_0000, 32'hC00A_BCDE,
              2, 32'h11, 32'h1002, 32'h0000_4000);
    run_entry("R2 break max trap", 1, 8'hFF, 0, 0, 32'hFFFF_FFFE, 32'h0001_0000,
              32'h3FFF_FFFF, 0, 32'hFF, 32'h0000_0000, 32'hCAFE_F00D);
    // R3 miss
    run_entry("R3 miss", 0, 8'h00, 1, 0, 32'h2344, 32'h4000, 32'h8000_0001,
              0, 32'h4, 32'h2344, 32'h1111_2222);
    // R4 interrupts
    run_entry("R4 irq bit10", 0, 8'h00, 0, 32'h0000_0500, 32'h7770, 32'h2000,
              32'h0000_0004, 1, 32'h3A, 32'h7770, 32'h3333_4444);
    run_entry("R4 irq bit31", 0, 8'h00, 0, 32'h8000_0001, 32'h10, 32'h2000,
              32'h4123_4567, 0, 32'h4F, 32'h10, 32'h5555_6666);
    run_entry("R4 irq bit0", 0, 8'h00, 0, 32'h0000_0001, 32'h20, 32'h0,
              32'h0000_0004, 0, 32'h30, 32'h20, 32'h7777_8888);
    // R8 priority
    run_entry("R8 break beats all", 1, 8'h09, 1, 32'h0000_00F0, 32'h300, 32'h9000,
              32'h0000_0004, 0, 32'h09, 32'h302, 32'h9999_0000);
    run_entry("R8 miss beats irq", 0, 8'h00, 1, 32'h0000_00F0, 32'h400, 32'h9000,
              32'h0000_0004, 0, 32'h4, 32'h400, 32'hAAAA_0000);
    run_entry("R8 break with masked irq", 1, 8'h02, 0, 32'h1, 32'h500, 32'h0,
              32'h0000_0000, 0, 32'h2, 32'h502, 32'hBBBB_0000);
    // R5 ignored interrupts
    expect_ignored("R5 empty mask", 32'h0, 32'h0000_0004);
    expect_ignored("R5 enable clear", 32'h0000_0100, 32'hFFFF_FFFB);
    // R10 reset mid fetch
    test_reset_midway();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule